// File: doc/BRIEF.md
# Carrier-Compared Space-Vector Modulator with Common-Mode Offset

This block drives the three legs of a two-level inverter bridge. Each leg gets a pair of gate commands, one for the upper switch and one for the lower switch. It produces space-vector-equivalent switching without working out which sector the reference lies in. Instead it adds one arithmetic common-mode offset to all three signed phase references. It then compares each shifted reference against a shared triangular carrier, in the same way as plain sine-triangle modulation. The offset inserts the triplen content that cancels between phases. This lets the line voltages reach about 15% more than sine-triangle modulation: a phase fundamental of Vdc/√3 instead of Vdc/2.

Two offset laws can be selected. The centered law shifts the references so that the largest and the smallest sit symmetrically about zero. This splits the zero-vector time evenly between the all-upper and all-lower states. The clamped law shifts the references until the leg with the largest magnitude meets a rail. That leg then stays put for a whole carrier period and only one zero vector is used. The offset and the shifted references are computed once per carrier period, at the carrier trough, and held until the next trough. Producing the references and inserting dead time are left to neighbouring blocks.

Top module: `cmi_svpwm`

## Requirements
- R1: For every leg, the lower-switch output is always the exact complement of the upper-switch output.
- R2: While reset is asserted, every upper-switch output is 0 and every lower-switch output is 1. The carrier restarts at its trough.
- R3: The carrier is a triangle of period 4·FS−2 cycles, where FS = 2^(DW−1)−1. It steps by one per cycle from −FS up to FS−1 and back down to −FS. References and mode are taken only on the clock edge at which the carrier sits at −FS. Changes at any other time have no effect until the next trough.
- R4: A leg's upper switch is on in a cycle when the leg's held duty value d is greater than the carrier value. Over one carrier period the upper-on count is 0 for d = −FS, 4·FS−2 for d = FS, and 2·(d+FS)−1 otherwise.
- R5: With mode_sel = 0 (centered), the offset is floor(−(max+min)/2) of the three references.
- R6: With mode_sel = 1 (clamped), let A = FS − max and B = −FS − min. The offset is A when |A| ≤ |B|, otherwise B.
- R7: Each shifted reference (reference plus offset) is saturated to the range −FS..+FS before it is held.
- R8: In clamped mode, at least one leg is held at a rail for the whole carrier period. Its upper-on count is either 0 or the full period.
- R9: The mode select is sampled together with the references at the trough. A mode change between troughs has no effect on the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | DW | Signed reference, leg a (bit 0 of the outputs) |
| ref_b | input | DW | Signed reference, leg b (bit 1 of the outputs) |
| ref_c | input | DW | Signed reference, leg c (bit 2 of the outputs) |
| mode_sel | input | 1 | 0 = centered offset, 1 = clamped offset |
| sw_hi | output | 3 | Upper-switch gate commands, one bit per leg |
| sw_lo | output | 3 | Lower-switch gate commands, one bit per leg |

## Verification
References take effect at the first clock edge after reset release and then every 4·FS−2 edges. The gate outputs are registered against the carrier value that the same edge produces. So the upper-on count for one set of references lies exactly in the samples taken after edges 1 to 4·FS−2 of that period. The bench drives each new reference set on the falling edge just before a trough edge. It counts gate samples on falling edges in windows of one period aligned to those troughs, and compares each window's counts with the expected values queued for it. Inputs that are disturbed halfway through a window must leave the counts of that window unchanged.

// File: rtl/cmi_svpwm_pkg.sv
package cmi_svpwm_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic {
        MODE_CENTERED = 1'b0,
        MODE_CLAMPED  = 1'b1
    } zero_mode_e;

endpackage

// File: rtl/cmi_carrier.sv
module cmi_carrier #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic signed [DW:0] car_nxt_o,
    output logic              trough_o
);
    localparam int FS = (2 ** (DW - 1)) - 1;
    localparam int CW = DW + 1;
    localparam logic signed [CW-1:0] C_LO  = CW'(-FS);
    localparam logic signed [CW-1:0] C_HI  = CW'(FS - 1);
    localparam logic signed [CW-1:0] C_ONE = CW'(1);

    typedef struct packed {
        logic signed [CW-1:0] cnt;
        logic                 down;
    } car_state_t;

    car_state_t st_d, st_q;

    // next carrier value and direction
    always_comb begin
        st_d = st_q;
        if (st_q.down) begin
            if (st_q.cnt == C_LO) begin
                st_d.down = 1'b0;
                st_d.cnt  = st_q.cnt + C_ONE;
            end else begin
                st_d.cnt  = st_q.cnt - C_ONE;
            end
        end else begin
            if (st_q.cnt == C_HI) begin
                st_d.down = 1'b1;
                st_d.cnt  = st_q.cnt - C_ONE;
            end else begin
                st_d.cnt  = st_q.cnt + C_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: C_LO, down: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign car_nxt_o = st_d.cnt;
    assign trough_o  = (st_q.cnt == C_LO);

    // R3
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt >= C_LO) && (st_q.cnt <= C_HI));

    // R3
    carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.cnt == $past(st_q.cnt) + C_ONE) ||
                  (st_q.cnt == $past(st_q.cnt) - C_ONE)));

endmodule

// File: rtl/cmi_offset.sv
module cmi_offset
    import cmi_svpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic signed [DW-1:0] ref_i  [NUM_LEGS],
    input  zero_mode_e           mode_i,
    output logic signed [DW:0]   duty_o [NUM_LEGS]
);
    localparam int FS = (2 ** (DW - 1)) - 1;
    localparam int CW = DW + 1;
    localparam int WW = DW + 3;
    localparam logic signed [WW-1:0] W_POS = WW'(FS);
    localparam logic signed [WW-1:0] W_NEG = WW'(-FS);
    localparam logic signed [CW-1:0] C_POS = CW'(FS);
    localparam logic signed [CW-1:0] C_NEG = CW'(-FS);

    logic signed [WW-1:0] ext [NUM_LEGS];
    logic signed [WW-1:0] mx, mn, sum_mm, off_ctr;
    logic signed [WW-1:0] to_top, to_bot, mag_top, mag_bot, off_sel;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_ext
        assign ext[g] = WW'(ref_i[g]);
    end

    // extremes of the three references
    always_comb begin
        mx = ext[0];
        mn = ext[0];
        for (int k = 1; k < NUM_LEGS; k++) begin
            if (ext[k] > mx) mx = ext[k];
            if (ext[k] < mn) mn = ext[k];
        end
    end

    // offset laws
    always_comb begin
        sum_mm  = mx + mn;
        off_ctr = (-sum_mm) >>> 1;
        to_top  = W_POS - mx;
        to_bot  = W_NEG - mn;
        mag_top = (to_top < 0) ? -to_top : to_top;
        mag_bot = (to_bot < 0) ? -to_bot : to_bot;
        if (mode_i == MODE_CLAMPED) begin
            off_sel = (mag_top <= mag_bot) ? to_top : to_bot;
        end else begin
            off_sel = off_ctr;
        end
    end

    // shift and saturate each leg
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_sat
        logic signed [WW-1:0] shifted;
        assign shifted   = ext[g] + off_sel;
        assign duty_o[g] = (shifted > W_POS) ? C_POS :
                           (shifted < W_NEG) ? C_NEG : CW'(shifted);
    end

endmodule

// File: rtl/cmi_leg.sv
module cmi_leg #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trough_i,
    input  logic signed [DW:0] car_nxt_i,
    input  logic signed [DW:0] duty_i,
    output logic              hi_o,
    output logic              lo_o,
    output logic signed [DW:0] duty_q_o
);
    localparam int FS = (2 ** (DW - 1)) - 1;
    localparam int CW = DW + 1;
    localparam logic signed [CW-1:0] C_POS = CW'(FS);
    localparam logic signed [CW-1:0] C_NEG = CW'(-FS);

    typedef struct packed {
        logic signed [CW-1:0] duty;
        logic                 hi;
        logic                 lo;
    } leg_state_t;

    leg_state_t st_d, st_q;
    logic       above;

    always_comb begin
        st_d = st_q;
        if (trough_i) begin
            st_d.duty = duty_i;
        end
        above   = (st_d.duty > car_nxt_i);
        st_d.hi = above;
        st_d.lo = !above;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{duty: '0, hi: 1'b0, lo: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o     = st_q.hi;
    assign lo_o     = st_q.lo;
    assign duty_q_o = st_q.duty;

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trough_i |=> $stable(st_q.duty));

    // R7
    duty_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.duty >= C_NEG) && (st_q.duty <= C_POS));

    // R4
    top_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.duty == C_POS) |-> st_q.hi);

    // R4
    bot_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.duty == C_NEG) |-> !st_q.hi);

endmodule

// File: rtl/cmi_svpwm.sv
module cmi_svpwm
    import cmi_svpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [DW-1:0] ref_a,
    input  logic signed [DW-1:0] ref_b,
    input  logic signed [DW-1:0] ref_c,
    input  logic                mode_sel,
    output logic [NUM_LEGS-1:0] sw_hi,
    output logic [NUM_LEGS-1:0] sw_lo
);
    localparam int FS = (2 ** (DW - 1)) - 1;
    localparam int CW = DW + 1;
    localparam logic signed [CW-1:0] C_POS = CW'(FS);
    localparam logic signed [CW-1:0] C_NEG = CW'(-FS);

    logic signed [DW-1:0] refs     [NUM_LEGS];
    logic signed [CW-1:0] duty_new [NUM_LEGS];
    logic signed [CW-1:0] duty_hld [NUM_LEGS];
    logic signed [CW-1:0] car_nxt;
    logic                 trough;
    zero_mode_e           mode;
    logic                 any_rail;

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = ref_c;
    assign mode    = zero_mode_e'(mode_sel);

    cmi_carrier #(.DW(DW)) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .car_nxt_o (car_nxt),
        .trough_o  (trough)
    );

    cmi_offset #(.DW(DW)) u_offset (
        .ref_i  (refs),
        .mode_i (mode),
        .duty_o (duty_new)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        cmi_leg #(.DW(DW)) u_leg (
            .clk       (clk),
            .rst       (rst),
            .trough_i  (trough),
            .car_nxt_i (car_nxt),
            .duty_i    (duty_new[g]),
            .hi_o      (sw_hi[g]),
            .lo_o      (sw_lo[g]),
            .duty_q_o  (duty_hld[g])
        );
    end

    always_comb begin
        any_rail = 1'b0;
        for (int k = 0; k < NUM_LEGS; k++) begin
            if ((duty_hld[k] == C_POS) || (duty_hld[k] == C_NEG)) any_rail = 1'b1;
        end
    end

    // R8
    clamp_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (trough && (mode == MODE_CLAMPED)) |=> any_rail);

endmodule

// File: tb/cmi_svpwm_bench.sv
`timescale 1ns/1ps
module cmi_svpwm_bench;
    localparam int DW = 8;
    localparam int FS = (2 ** (DW - 1)) - 1;
    localparam int P  = 4 * FS - 2;

    typedef struct {
        int    cnt [3];
        bit    clamped;
        string tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic                 mode_sel = 1'b0;
    logic [2:0]           sw_hi, sw_lo;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    bit   wd_hit  = 1'b0;
    exp_t sb_q [$];

    always #2.5 clk = ~clk;

    cmi_svpwm #(.DW(DW)) u_cmi_svpwm (
        .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .mode_sel(mode_sel), .sw_hi(sw_hi), .sw_lo(sw_lo)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > FS) ? FS : ((v < -FS) ? -FS : v);
    endfunction

    function automatic int on_count(input int d);
        if (d <= -FS) return 0;
        if (d >= FS)  return P;
        return 2 * (d + FS) - 1;
    endfunction

    function automatic int offset_of(input int r0, input int r1, input int r2,
                                     input bit clamped);
        int mx, mn, s, a, b;
        mx = r0; mn = r0;
        if (r1 > mx) mx = r1;
        if (r2 > mx) mx = r2;
        if (r1 < mn) mn = r1;
        if (r2 < mn) mn = r2;
        if (!clamped) begin
            s = -(mx + mn);
            return (s >= 0) ? s / 2 : -((-s + 1) / 2);
        end
        a = FS - mx;
        b = -FS - mn;
        return (((a < 0) ? -a : a) <= ((b < 0) ? -b : b)) ? a : b;
    endfunction

    // driver: set one reference set for exactly one carrier period
    task automatic apply(input int r0, input int r1, input int r2,
                         input bit clamped, input bit junk, input string tag);
        exp_t e;
        int   off;
        ref_a    = DW'(r0);
        ref_b    = DW'(r1);
        ref_c    = DW'(r2);
        mode_sel = clamped;
        off      = offset_of(r0, r1, r2, clamped);
        e.cnt[0] = on_count(sat(r0 + off));
        e.cnt[1] = on_count(sat(r1 + off));
        e.cnt[2] = on_count(sat(r2 + off));
        e.clamped = clamped;
        e.tag     = tag;
        sb_q.push_back(e);
        if (junk) begin
            repeat (P / 2) @(negedge clk);
            ref_a    = DW'(100);
            ref_b    = DW'(-90);
            ref_c    = DW'(5);
            mode_sel = !clamped;
            repeat (P - P / 2) @(negedge clk);
        end else begin
            repeat (P) @(negedge clk);
        end
    endtask

    task automatic monitor_loop();
        forever begin
            int   cnt [3];
            bit   comp_ok;
            bit   rail;
            exp_t e;
            cnt = '{0, 0, 0};
            comp_ok = 1'b1;
            for (int i = 0; i < P; i++) begin
                @(negedge clk);
                for (int k = 0; k < 3; k++) cnt[k] += int'(sw_hi[k]);
                if (sw_lo !== ~sw_hi) comp_ok = 1'b0;
            end
            e = sb_q.pop_front();
            for (int k = 0; k < 3; k++) begin
                check(cnt[k] == e.cnt[k], {e.tag, " R4"},
                      $sformatf("leg %0d upper-on count", k), cnt[k], e.cnt[k]);
            end
            // R1
            check(comp_ok, "R1", "lower equals complement of upper", int'(comp_ok), 1);
            if (e.clamped) begin
                rail = 1'b0;
                for (int k = 0; k < 3; k++) if (cnt[k] == 0 || cnt[k] == P) rail = 1'b1;
                // R8
                check(rail, "R8", "some leg held at a rail", int'(rail), 1);
            end
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R2
        check(sw_hi == 3'b000, "R2", "upper outputs in reset", int'(sw_hi), 0);
        check(sw_lo == 3'b111, "R2", "lower outputs in reset", int'(sw_lo), 7);
        rst = 1'b0;
        fork
            begin
                apply(40, -10, -30, 1'b0, 1'b0, "R5");
                apply(40, -10, -30, 1'b1, 1'b0, "R6");
                apply(-100, 50, 30, 1'b1, 1'b0, "R6");
                apply(127, -128, 0, 1'b0, 1'b0, "R7");
                apply(-7, 0, 0, 1'b0, 1'b0, "R5");
                apply(127, 127, 127, 1'b0, 1'b0, "R5");
                apply(127, 127, 127, 1'b1, 1'b0, "R7");
                apply(10, -10, 0, 1'b1, 1'b0, "R6");
                apply(60, -20, -40, 1'b0, 1'b1, "R3");
                apply(60, -20, -40, 1'b1, 1'b1, "R9");
                apply(-128, -128, 127, 1'b1, 1'b0, "R7");
                apply(0, 0, 0, 1'b0, 1'b0, "R4");
                done = 1'b1;
            end
            monitor_loop();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_none
        wait (done || wd_hit);
        repeat (3) @(negedge clk);
        if (wd_hit && !done) begin
            check(1'b0, "R3", "watchdog expired before all periods", 0, 1);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule